// File: doc/BRIEF.md
# Chained Descriptor Ring DMA Walker

This block walks a ring of transfer descriptors in memory for a storage-card host controller. Software fills in four-word descriptors and hands each one to hardware by setting its ownership bit. It then writes the ring base address and pulses start. The walker reads each descriptor over a simple word-wide memory request port. It checks the ownership bit, the length and the alignment, and then issues one request to the data mover, carrying the buffer address, the byte count and the first/last markers. The card data path behind the mover is modelled only as a done/error handshake.

When the mover reports done, the walker writes the control word back with ownership returned to software and the error summary bit updated. It then picks the next descriptor. That is the ring base when the end-of-ring flag is set, the fourth word when chaining is set, and otherwise the next 16-byte slot. A per-descriptor interrupt flag can suppress the completion pulse, but not when the transfer failed. The walker stops after the descriptor marked last. It also stops when it meets a descriptor it does not own, a misaligned address or an oversized segment, and it holds a sticky status flag for each of these stops until the next start.

Descriptor layout: word 0 is the control word, word 1 holds the byte count in bits 12:0, word 2 is the buffer address and word 3 is the next pointer. In word 0, bit 31 is the ownership bit, bit 30 the error summary, bit 5 end-of-ring, bit 4 chained, bit 3 first, bit 2 last and bit 1 interrupt suppression.

Top module: `chain_dma_walker`

## Requirements
- R1: After reset, busy_o, mem_req_o, mv_req_o, irq_o, done_o, unavail_o and bus_err_o are all 0.
- R2: A start pulse while idle makes the walker read the four words of the descriptor at base_addr_i. If word 0 bit 31 is 0, it stops with unavail_o set and issues no mover request and no write-back.
- R3: For each owned descriptor with a non-zero count, the walker issues one mover request: mv_addr_o = word 2, mv_len_o = word 1 bits 12:0, mv_first_o = word 0 bit 3, mv_last_o = word 0 bit 2 and mv_burst_o = 2. The request stays asserted and stable until mv_done_i.
- R4: When a descriptor is finished, word 0 is written back to the same address with bit 31 cleared and bit 30 set exactly when mv_err_i was high with mv_done_i. All other bits are unchanged.
- R5: If the last flag is clear, the next descriptor is at word 3 when bit 4 is set, and at the current address + 16 when bit 4 is clear.
- R6: Bit 5 (end-of-ring) sends the walker back to the ring base address. This takes priority over word 3.
- R7: A count of 0 skips the data move. The descriptor is still written back and the walk continues.
- R8: After the write-back of a descriptor with bit 2 set, the walker goes idle and pulses done_o for one cycle.
- R9: After each write-back, irq_o pulses for one cycle unless bit 1 is set and no error was reported.
- R10: A base, buffer (non-zero count) or next address with bits 1:0 non-zero stops the walker with bus_err_o set. No request is issued for the bad address.
- R11: A count above 4096 stops the walker with bus_err_o set and no mover request.
- R12: An accepted start clears unavail_o and bus_err_o.
- R13: mem_req_o, mem_we_o and mem_addr_o stay stable from the first cycle of a request until mem_ack_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| base_addr_i | input | AW | Ring base address |
| busy_o | output | 1 | Walker active |
| mem_req_o | output | 1 | Memory word request |
| mem_we_o | output | 1 | 1 = write-back, 0 = descriptor read |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 32 | Write-back data |
| mem_ack_i | input | 1 | Memory request completed |
| mem_rdata_i | input | 32 | Read data, valid with mem_ack_i |
| mv_req_o | output | 1 | Data mover request |
| mv_addr_o | output | AW | Buffer address |
| mv_len_o | output | 13 | Byte count |
| mv_burst_o | output | 3 | Burst-size setting |
| mv_first_o | output | 1 | First segment of transfer |
| mv_last_o | output | 1 | Last segment of transfer |
| mv_done_i | input | 1 | Data mover finished |
| mv_err_i | input | 1 | Data mover error, valid with mv_done_i |
| irq_o | output | 1 | Per-descriptor completion pulse |
| done_o | output | 1 | Transfer-complete pulse |
| unavail_o | output | 1 | Sticky: stopped on a descriptor not owned |
| bus_err_o | output | 1 | Sticky: stopped on misalignment or oversize |

## Verification
The assertions check the handshake rules on every cycle: memory and mover requests stay stable until they are acknowledged, and the mover only ever sees an aligned address, a count from 1 to 4096 and the fixed burst setting. They also check that a write-back never returns ownership set, that a finished move is followed by a write-back, and that each stop status is raised only while idle. Only the bench scenarios can show that the walk follows the right path: end-of-ring priority over the chain pointer, contiguous stepping, zero-count skips, the written-back control word with its error bit, and the exact count of interrupt pulses under suppression.

// File: rtl/cdw_pkg.sv
package cdw_pkg;
  localparam int WORD_W    = 32;
  localparam int LEN_W     = 13;
  localparam int MAX_SEG   = 4096;
  localparam int BURST_W   = 3;
  localparam int BURST_DEF = 2;
  localparam int WPD       = 4;
  localparam int IDX_W     = $clog2(WPD);
  localparam int DESC_B    = WPD * (WORD_W / 8);

  // control word bit positions (software-visible)
  localparam int OWN_B   = 31;
  localparam int CES_B   = 30;
  localparam int EOR_B   = 5;
  localparam int CHAIN_B = 4;
  localparam int FIRST_B = 3;
  localparam int LAST_B  = 2;
  localparam int DIC_B   = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CHECK,
    ST_MOVE,
    ST_WB
  } state_e;

  typedef struct packed {
    logic own;
    logic eor;
    logic chain;
    logic first;
    logic last;
    logic dic;
  } ctl_t;
endpackage

// File: rtl/cdw_decode.sv
module cdw_decode
  import cdw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [WORD_W-1:0] ctl_w_i,
  input  logic [WORD_W-1:0] size_w_i,
  input  logic [AW-1:0]     buf_w_i,
  output ctl_t              ctl_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              len_zero_o,
  output logic              len_over_o,
  output logic              buf_misal_o
);
  always_comb begin
    ctl_o.own   = ctl_w_i[OWN_B];
    ctl_o.eor   = ctl_w_i[EOR_B];
    ctl_o.chain = ctl_w_i[CHAIN_B];
    ctl_o.first = ctl_w_i[FIRST_B];
    ctl_o.last  = ctl_w_i[LAST_B];
    ctl_o.dic   = ctl_w_i[DIC_B];
  end

  assign len_o       = size_w_i[LEN_W-1:0];
  assign len_zero_o  = (len_o == '0);
  assign len_over_o  = (int'(len_o) > MAX_SEG);
  assign buf_misal_o = (buf_w_i[1:0] != 2'b00);
endmodule

// File: rtl/cdw_next_addr.sv
module cdw_next_addr
  import cdw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] ptr_i,
  input  logic          chain_i,
  input  logic          eor_i,
  output logic [AW-1:0] nxt_o,
  output logic          misal_o
);
  localparam logic [AW-1:0] STEP = AW'(DESC_B);

  // end-of-ring has priority over the chain pointer
  always_comb begin
    if (eor_i)        nxt_o = base_i;
    else if (chain_i) nxt_o = ptr_i;
    else              nxt_o = cur_i + STEP;
  end

  assign misal_o = (nxt_o[1:0] != 2'b00);
endmodule

// File: rtl/cdw_event.sv
module cdw_event (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic wb_i,
  input  logic dic_i,
  input  logic err_i,
  input  logic last_i,
  input  logic unavail_i,
  input  logic bus_err_i,
  output logic irq_o,
  output logic done_o,
  output logic unavail_o,
  output logic bus_err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o     <= 1'b0;
      done_o    <= 1'b0;
      unavail_o <= 1'b0;
      bus_err_o <= 1'b0;
    end else begin
      irq_o  <= wb_i && (!dic_i || err_i);
      done_o <= wb_i && last_i;
      if (unavail_i)  unavail_o <= 1'b1;
      else if (clr_i) unavail_o <= 1'b0;
      if (bus_err_i)  bus_err_o <= 1'b1;
      else if (clr_i) bus_err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/chain_dma_walker.sv
module chain_dma_walker
  import cdw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [AW-1:0]      base_addr_i,
  output logic               busy_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [WORD_W-1:0]  mem_wdata_o,
  input  logic               mem_ack_i,
  input  logic [WORD_W-1:0]  mem_rdata_i,
  output logic               mv_req_o,
  output logic [AW-1:0]      mv_addr_o,
  output logic [LEN_W-1:0]   mv_len_o,
  output logic [BURST_W-1:0] mv_burst_o,
  output logic               mv_first_o,
  output logic               mv_last_o,
  input  logic               mv_done_i,
  input  logic               mv_err_i,
  output logic               irq_o,
  output logic               done_o,
  output logic               unavail_o,
  output logic               bus_err_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WPD - 1);

  state_e            state_q, state_d;
  logic [AW-1:0]     base_q, cur_q;
  logic [IDX_W-1:0]  widx_q;
  logic [WORD_W-1:0] words_q [WPD];
  logic              err_q;

  ctl_t              ctl;
  logic [LEN_W-1:0]  len;
  logic              len_zero, len_over, buf_misal;
  logic [AW-1:0]     nxt_addr;
  logic              nxt_misal;

  logic start_ok, ev_unavail, ev_bus_err, ev_wb;

  cdw_decode #(.AW(AW)) dec_i (
    .ctl_w_i     (words_q[0]),
    .size_w_i    (words_q[1]),
    .buf_w_i     (words_q[2][AW-1:0]),
    .ctl_o       (ctl),
    .len_o       (len),
    .len_zero_o  (len_zero),
    .len_over_o  (len_over),
    .buf_misal_o (buf_misal)
  );

  cdw_next_addr #(.AW(AW)) nxt_i (
    .cur_i   (cur_q),
    .base_i  (base_q),
    .ptr_i   (words_q[3][AW-1:0]),
    .chain_i (ctl.chain),
    .eor_i   (ctl.eor),
    .nxt_o   (nxt_addr),
    .misal_o (nxt_misal)
  );

  cdw_event evt_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (start_ok),
    .wb_i      (ev_wb),
    .dic_i     (ctl.dic),
    .err_i     (err_q),
    .last_i    (ctl.last),
    .unavail_i (ev_unavail),
    .bus_err_i (ev_bus_err),
    .irq_o     (irq_o),
    .done_o    (done_o),
    .unavail_o (unavail_o),
    .bus_err_o (bus_err_o)
  );

  assign start_ok = start_i && (state_q == ST_IDLE);

  always_comb begin
    state_d    = state_q;
    ev_unavail = 1'b0;
    ev_bus_err = 1'b0;
    ev_wb      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ok) begin
          if (base_addr_i[1:0] != 2'b00) ev_bus_err = 1'b1;
          else                           state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (mem_ack_i) begin
          if (widx_q == '0 && !mem_rdata_i[OWN_B]) begin
            ev_unavail = 1'b1;
            state_d    = ST_IDLE;
          end else if (widx_q == LAST_IDX) begin
            state_d = ST_CHECK;
          end
        end
      end
      ST_CHECK: begin
        if (len_over || (!len_zero && buf_misal)) begin
          ev_bus_err = 1'b1;
          state_d    = ST_IDLE;
        end else if (len_zero) begin
          state_d = ST_WB;
        end else begin
          state_d = ST_MOVE;
        end
      end
      ST_MOVE: begin
        if (mv_done_i) state_d = ST_WB;
      end
      ST_WB: begin
        if (mem_ack_i) begin
          ev_wb = 1'b1;
          if (ctl.last) begin
            state_d = ST_IDLE;
          end else if (nxt_misal) begin
            ev_bus_err = 1'b1;
            state_d    = ST_IDLE;
          end else begin
            state_d = ST_FETCH;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      cur_q   <= '0;
      widx_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_ok) begin
        base_q <= base_addr_i;
        cur_q  <= base_addr_i;
        widx_q <= '0;
      end
      if (state_q == ST_FETCH && mem_ack_i) widx_q <= widx_q + 1'b1;
      if (state_q == ST_CHECK) err_q <= 1'b0;
      if (state_q == ST_MOVE && mv_done_i) err_q <= mv_err_i;
      if (ev_wb && state_d == ST_FETCH) begin
        cur_q  <= nxt_addr;
        widx_q <= '0;
      end
    end
  end

  for (genvar g = 0; g < WPD; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        words_q[g] <= '0;
      else if (state_q == ST_FETCH && mem_ack_i && widx_q == IDX_W'(g))
        words_q[g] <= mem_rdata_i;
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    if (state_q == ST_FETCH) begin
      mem_req_o  = 1'b1;
      mem_addr_o = cur_q + AW'({widx_q, 2'b00});
    end else if (state_q == ST_WB) begin
      mem_req_o   = 1'b1;
      mem_we_o    = 1'b1;
      mem_addr_o  = cur_q;
      mem_wdata_o = words_q[0];
      mem_wdata_o[OWN_B] = 1'b0;
      mem_wdata_o[CES_B] = err_q;
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign mv_req_o   = (state_q == ST_MOVE);
  assign mv_addr_o  = words_q[2][AW-1:0];
  assign mv_len_o   = len;
  assign mv_burst_o = BURST_W'(BURST_DEF);
  assign mv_first_o = ctl.first;
  assign mv_last_o  = ctl.last;
endmodule

// File: rtl/cdw_checker.sv
module cdw_checker
  import cdw_pkg::*;
#(
  parameter int AW = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               busy_o,
  input logic               mem_req_o,
  input logic               mem_we_o,
  input logic [AW-1:0]      mem_addr_o,
  input logic [WORD_W-1:0]  mem_wdata_o,
  input logic               mem_ack_i,
  input logic               mv_req_o,
  input logic [AW-1:0]      mv_addr_o,
  input logic [LEN_W-1:0]   mv_len_o,
  input logic [BURST_W-1:0] mv_burst_o,
  input logic               mv_done_i,
  input logic               irq_o,
  input logic               done_o,
  input logic               unavail_o,
  input logic               bus_err_o
);
  assert_mem_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  assert_mv_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mv_req_o && !mv_done_i) |=> (mv_req_o && $stable(mv_addr_o) && $stable(mv_len_o)));

  assert_mv_burst_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mv_req_o |-> (mv_burst_o == BURST_W'(BURST_DEF)));

  assert_mv_len_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mv_req_o |-> (mv_len_o != '0 && int'(mv_len_o) <= MAX_SEG));

  assert_mv_aligned_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mv_req_o |-> (mv_addr_o[1:0] == 2'b00));

  assert_wb_owner_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> !mem_wdata_o[OWN_B]);

  assert_wb_after_move_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mv_req_o && mv_done_i) |=> (mem_req_o && mem_we_o));

  assert_bus_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !mv_req_o));

  assert_irq_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_unavail_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unavail_o) |-> !busy_o);

  assert_buserr_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_err_o) |-> !busy_o);

  assert_buserr_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_err_o && !start_i) |=> bus_err_o);
endmodule

bind chain_dma_walker cdw_checker #(.AW(AW)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i),
  .mv_req_o    (mv_req_o),
  .mv_addr_o   (mv_addr_o),
  .mv_len_o    (mv_len_o),
  .mv_burst_o  (mv_burst_o),
  .mv_done_i   (mv_done_i),
  .irq_o       (irq_o),
  .done_o      (done_o),
  .unavail_o   (unavail_o),
  .bus_err_o   (bus_err_o)
);

// File: tb/chain_dma_walker_tb_top.sv
module chain_dma_walker_tb_top;
  localparam int AW = 32;
  localparam logic [31:0] OWN = 32'h8000_0000, CES = 32'h4000_0000;
  localparam logic [31:0] EOR = 32'h20, CH = 32'h10, FS = 32'h8, LD = 32'h4, DIC = 32'h2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_ni, start_i;
  logic [AW-1:0] base_addr_i;
  logic          busy_o, mem_req_o, mem_we_o, mem_ack_i;
  logic [AW-1:0] mem_addr_o;
  logic [31:0]   mem_wdata_o, mem_rdata_i;
  logic          mv_req_o, mv_first_o, mv_last_o, mv_done_i, mv_err_i;
  logic [AW-1:0] mv_addr_o;
  logic [12:0]   mv_len_o;
  logic [2:0]    mv_burst_o;
  logic          irq_o, done_o, unavail_o, bus_err_o;

  chain_dma_walker #(.AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .base_addr_i(base_addr_i),
    .busy_o(busy_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
    .mem_rdata_i(mem_rdata_i), .mv_req_o(mv_req_o), .mv_addr_o(mv_addr_o),
    .mv_len_o(mv_len_o), .mv_burst_o(mv_burst_o), .mv_first_o(mv_first_o),
    .mv_last_o(mv_last_o), .mv_done_i(mv_done_i), .mv_err_i(mv_err_i),
    .irq_o(irq_o), .done_o(done_o), .unavail_o(unavail_o), .bus_err_o(bus_err_o)
  );

  typedef struct {
    logic [31:0] a;
    logic [12:0] l;
    logic        f;
    logic        ls;
  } mv_t;

  mv_t         exp_q[$];
  logic [31:0] mem [256];
  int total = 0, bad = 0;
  int irq_cnt = 0, done_cnt = 0, mv_cnt = 0, mem_cnt = 0;
  logic err_plan = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_move(input logic [31:0] a, input logic [12:0] l, input logic f, input logic ls);
    mv_t m;
    m.a = a; m.l = l; m.f = f; m.ls = ls;
    exp_q.push_back(m);
  endtask

  task automatic put_desc(input logic [31:0] at, input logic [31:0] c, input logic [31:0] sz,
                          input logic [31:0] b, input logic [31:0] n);
    mem[at[9:2]]      = c;
    mem[at[9:2] + 1]  = sz;
    mem[at[9:2] + 2]  = b;
    mem[at[9:2] + 3]  = n;
  endtask

  task automatic run(input logic [31:0] base);
    irq_cnt = 0; done_cnt = 0; mv_cnt = 0; mem_cnt = 0;
    @(negedge clk);
    base_addr_i = base;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R3 moves outstanding", exp_q.size(), 0);
    exp_q.delete();
  endtask

  // memory model
  initial begin
    mem_ack_i = 1'b0;
    mem_rdata_i = '0;
    forever begin
      @(negedge clk);
      if (mem_ack_i) mem_ack_i = 1'b0;
      else if (mem_req_o) begin
        if (mem_we_o) mem[mem_addr_o[9:2]] = mem_wdata_o;
        else mem_rdata_i = mem[mem_addr_o[9:2]];
        mem_ack_i = 1'b1;
        mem_cnt++;
      end
    end
  end

  // data mover model + scoreboard monitor
  initial begin
    int dly;
    dly = 2;
    mv_done_i = 1'b0;
    mv_err_i = 1'b0;
    forever begin
      @(negedge clk);
      if (mv_done_i) begin
        mv_done_i = 1'b0;
        mv_err_i = 1'b0;
      end else if (mv_req_o) begin
        if (dly > 0) dly--;
        else begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R3 unexpected move addr", mv_addr_o, 0);
          end else begin
            mv_t m;
            m = exp_q.pop_front();
            chk(mv_addr_o == m.a, "R3 move addr", mv_addr_o, m.a);
            chk(mv_len_o == m.l, "R3 move len", 32'(mv_len_o), 32'(m.l));
            chk({mv_first_o, mv_last_o} == {m.f, m.ls}, "R3 first/last",
                32'({mv_first_o, mv_last_o}), 32'({m.f, m.ls}));
            chk(mv_burst_o == 3'd2, "R3 burst", 32'(mv_burst_o), 2);
          end
          mv_done_i = 1'b1;
          mv_err_i = err_plan;
          dly = 2;
          mv_cnt++;
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (irq_o) irq_cnt++;
      if (done_o) done_cnt++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    rst_ni = 1'b0; start_i = 1'b0; base_addr_i = '0;
    repeat (3) @(negedge clk);
    chk({busy_o, mem_req_o, mv_req_o, irq_o, done_o, unavail_o, bus_err_o} == '0,
        "R1 reset outputs", 32'({busy_o, mem_req_o, mv_req_o, irq_o, done_o, unavail_o, bus_err_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // chained list with a zero-count skip; R5 R7 R8 R9
    put_desc(32'h40, OWN | FS | CH, 100, 32'h1000, 32'h80);
    put_desc(32'h80, OWN | CH | DIC, 0, 32'h1003, 32'hC0);
    put_desc(32'hC0, OWN | LD | DIC | CH, 4096, 32'h2000, 32'h40);
    expect_move(32'h1000, 100, 1'b1, 1'b0);
    expect_move(32'h2000, 4096, 1'b0, 1'b1);
    run(32'h40);
    chk(mv_cnt == 2, "R7 skip move count", mv_cnt, 2);
    chk(mem[32'h40 >> 2] == (FS | CH), "R4 wb word0 d0", mem[32'h40 >> 2], FS | CH);
    chk(mem[32'h80 >> 2] == (CH | DIC), "R7 skip written back", mem[32'h80 >> 2], CH | DIC);
    chk(mem[32'hC0 >> 2] == (LD | DIC | CH), "R4 wb word0 d2", mem[32'hC0 >> 2], LD | DIC | CH);
    chk(irq_cnt == 1, "R9 irq suppression", irq_cnt, 1);
    chk(done_cnt == 1, "R8 done pulse", done_cnt, 1);
    chk(mem_cnt == 15, "R5 R8 memory accesses", mem_cnt, 15);

    // end-of-ring wrap, trap at the chain pointer; R6 R2
    put_desc(32'h100, OWN | CH | DIC, 8, 32'h3000, 32'h180);
    put_desc(32'h180, OWN | EOR | CH | DIC, 12, 32'h3100, 32'h300);
    put_desc(32'h300, OWN | LD, 4, 32'h3200, 32'h0);
    expect_move(32'h3000, 8, 1'b0, 1'b0);
    expect_move(32'h3100, 12, 1'b0, 1'b0);
    run(32'h100);
    chk(mv_cnt == 2, "R6 wrap move count", mv_cnt, 2);
    chk(unavail_o == 1'b1, "R2 unavail after wrap", 32'(unavail_o), 1);
    chk(mem[32'h300 >> 2] == (OWN | LD), "R6 trap untouched", mem[32'h300 >> 2], OWN | LD);
    chk(done_cnt == 0, "R8 no done on unavail", done_cnt, 0);
    chk(mem_cnt == 11, "R2 stops after word0", mem_cnt, 11);

    // contiguous step, pointer ignored; R5 R12
    put_desc(32'h200, OWN | FS, 16, 32'h4000, 32'h300);
    put_desc(32'h210, OWN | LD, 32, 32'h4100, 32'h300);
    expect_move(32'h4000, 16, 1'b1, 1'b0);
    expect_move(32'h4100, 32, 1'b0, 1'b1);
    run(32'h200);
    chk(unavail_o == 1'b0, "R12 start clears unavail", 32'(unavail_o), 0);
    chk(mv_cnt == 2 && done_cnt == 1, "R5 contiguous walk", mv_cnt, 2);
    chk(irq_cnt == 2, "R9 irq per descriptor", irq_cnt, 2);
    chk(mem[32'h210 >> 2] == LD, "R5 wb second slot", mem[32'h210 >> 2], LD);

    // mover error overrides suppression; R4 R9
    err_plan = 1'b1;
    put_desc(32'h40, OWN | FS | LD | DIC, 64, 32'h5000, 32'h0);
    expect_move(32'h5000, 64, 1'b1, 1'b1);
    run(32'h40);
    err_plan = 1'b0;
    chk(mem[32'h40 >> 2] == (CES | FS | LD | DIC), "R4 error summary bit",
        mem[32'h40 >> 2], CES | FS | LD | DIC);
    chk(irq_cnt == 1, "R9 irq on error", irq_cnt, 1);

    // misaligned buffer; R10
    put_desc(32'h40, OWN | LD, 8, 32'h5002, 32'h0);
    run(32'h40);
    chk(bus_err_o == 1'b1, "R10 buffer misaligned", 32'(bus_err_o), 1);
    chk(mv_cnt == 0, "R10 no move", mv_cnt, 0);
    chk(mem[32'h40 >> 2] == (OWN | LD), "R10 no write-back", mem[32'h40 >> 2], OWN | LD);

    // good run clears bus error; R12
    put_desc(32'h80, OWN | FS | LD, 4, 32'h6000, 32'h0);
    expect_move(32'h6000, 4, 1'b1, 1'b1);
    run(32'h80);
    chk(bus_err_o == 1'b0, "R12 start clears bus error", 32'(bus_err_o), 0);
    chk(done_cnt == 1, "R8 single descriptor done", done_cnt, 1);

    // misaligned base; R10
    run(32'h42);
    chk(bus_err_o == 1'b1, "R10 base misaligned", 32'(bus_err_o), 1);
    chk(mem_cnt == 0, "R10 no memory access", mem_cnt, 0);

    // oversize segment; R11
    put_desc(32'hC0, OWN | LD, 4097, 32'h7000, 32'h0);
    run(32'hC0);
    chk(bus_err_o == 1'b1, "R11 oversize", 32'(bus_err_o), 1);
    chk(mv_cnt == 0, "R11 no move", mv_cnt, 0);

    // misaligned next pointer; R10 R5
    put_desc(32'h140, OWN | CH, 4, 32'h7100, 32'h1A2);
    expect_move(32'h7100, 4, 1'b0, 1'b0);
    run(32'h140);
    chk(bus_err_o == 1'b1, "R10 next misaligned", 32'(bus_err_o), 1);
    chk(mem[32'h140 >> 2] == CH, "R4 wb before next check", mem[32'h140 >> 2], CH);
    chk(mem_cnt == 5, "R10 no fetch at bad next", mem_cnt, 5);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule